// File: doc/BRIEF.md
# Packet-Level Handshake Ingress Receiver

This block is the receive end of a 32-bit ingress bus on which a sender moves fixed-length packets of sixteen words. The receiver drives an active-low ready line. That line grants room for one whole packet at a time. A packet opens on a start-of-packet strobe, which counts only while the sender shows packet-available. The receiver then counts words until the packet closes. It checks odd parity per word when checking is switched on, and flags a start strobe that arrives inside an open packet. Every word it accepts goes into an internal buffer that holds two packets. The buffer feeds a valid/ready/last stream towards downstream logic.

The sender reacts to the ready line only two cycles after it changes. For this reason, ready is re-decided at one fixed point near the end of each packet, and at all times while no packet is open. At that point the words still to come in the open packet are counted as already used. Ready is granted only when a further full packet would also fit after them. Errors never drop a packet: it is delivered whole, and its last beat carries the error flag.

Top module: `pkt_ingress_rx`

## Requirements
- R1: Each 32-bit word that the receiver accepts leaves on m_data unchanged (bit 0 is the least significant bit), and words leave in the order they arrived.
- R2: A packet opens only on a cycle with rx_sop=1 and rx_avail=1 while no packet is open. A start strobe while rx_avail=0, and any word that arrives while no packet is open, is ignored and produces no output beat.
- R3: A packet is exactly PKT_WORDS (16) words long, counting the opening word, and m_last is 1 on its final beat only.
- R4: With par_chk_en=1, a word has a parity error when the 33 bits {rx_par, rx_word} hold an even number of ones. With par_chk_en=0, rx_par has no effect.
- R5: A packet that has any parity or framing error is still delivered with all its words, and m_err=1 on its last beat. m_err is 0 on every other beat and on every beat of a clean packet.
- R6: rx_sop=1 on word index 1..15 of an open packet is a framing error. It neither restarts the word count nor drops the word, which is delivered as ordinary data.
- R7: rx_ready_n is active low. While a packet is open, it changes only at the clock edge that samples word index PKT_WORDS-3 (13), so the new value is visible while word 14 is on the bus.
- R8: At that decision edge, and at every edge while no packet is open, rx_ready_n becomes 0 exactly when buffer level + words still to come in the open packet (PKT_WORDS - index, or 0 when idle) + PKT_WORDS <= 2*PKT_WORDS (32).
- R9: With m_ready=0 the head beat is held stable. A beat leaves only when m_valid=1 and m_ready=1. A sender that obeys the ready line never overflows the buffer.
- R10: During reset rx_ready_n=1 and m_valid=0. Reset empties the buffer and closes any open packet. In the first cycle after reset, rx_ready_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_chk_en | input | 1 | Enables the odd-parity check |
| rx_word | input | 32 | Ingress data word |
| rx_par | input | 1 | Odd parity bit over rx_word |
| rx_avail | input | 1 | Sender has a complete packet to send |
| rx_sop | input | 1 | First word of a packet |
| rx_ready_n | output | 1 | Active-low room for one whole packet |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the beat |
| m_data | output | 32 | Output word |
| m_last | output | 1 | Final beat of a packet |
| m_err | output | 1 | Packet error, meaningful on the last beat |

## Verification
A word counter that is off by one shows up on the first packet at the ports. m_last lands on the wrong beat, and rx_ready_n moves one word early or late at the decision point. An error flag that stays set past a packet boundary marks the next clean packet as bad. A wrong buffer level shows only under backpressure, where rx_ready_n stays low when a second buffered packet should have cleared it, or stays high after the buffer has drained. The bench therefore sweeps the position of every bad-parity and early-start word, and fills the buffer to its reservation limit.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    // Per-beat side information stored beside each data word.
    typedef struct packed {
        logic last;
        logic err;
    } rx_tag_t;

endpackage

// File: rtl/rx_word_framer.sv
module rx_word_framer
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PKT_WORDS = 16,
    localparam int IDX_W    = $clog2(PKT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_chk_en,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_par,
    input  logic              rx_avail,
    input  logic              rx_sop,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output rx_tag_t           wr_tag,
    output logic              pkt_open,
    output logic [IDX_W-1:0]  pkt_idx
);

    typedef struct packed {
        logic             open;
        logic [IDX_W-1:0] idx;
        logic             par_bad;
        logic             frm_bad;
    } frm_st_t;

    frm_st_t st_q, st_d;

    logic start_w, take_w, word_bad_w, early_w, at_end_w;

    always_comb begin
        st_d       = st_q;
        start_w    = rx_sop && rx_avail && !st_q.open;
        take_w     = st_q.open || start_w;
        // odd parity: all 33 bits must carry an odd count of ones
        word_bad_w = par_chk_en && !(^{rx_par, rx_word});
        early_w    = st_q.open && rx_sop;
        at_end_w   = take_w && (st_q.idx == IDX_W'(PKT_WORDS - 1));

        wr_en      = take_w;
        wr_data    = rx_word;
        wr_tag.last = at_end_w;
        wr_tag.err  = at_end_w && (st_q.par_bad || st_q.frm_bad || word_bad_w || early_w);

        if (take_w) begin
            if (at_end_w) begin
                st_d = '0;
            end else begin
                st_d.open    = 1'b1;
                st_d.idx     = st_q.idx + IDX_W'(1);
                st_d.par_bad = st_q.par_bad || word_bad_w;
                st_d.frm_bad = st_q.frm_bad || early_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_open = st_q.open;
    assign pkt_idx  = st_q.idx;

    // R2: a packet can only have opened on a qualified start strobe
    a_r2_open_needs_sop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.open) |-> $past(rx_sop && rx_avail));

    // R3: the beat marked last always closes the packet
    a_r3_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tag.last) |=> !st_q.open);

endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  rx_tag_t           push_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output rx_tag_t           out_tag,
    output logic [LVL_W-1:0]  level
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [DATA_W+1:0] mem_q [DEPTH];
    logic pop_w;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        out_valid = (st_q.lvl != '0);
        pop_w     = out_valid && out_ready;
        {out_tag, out_data} = mem_q[st_q.rd];
        if (push)  st_d.wr = ptr_inc(st_q.wr);
        if (pop_w) st_d.rd = ptr_inc(st_q.rd);
        st_d.lvl = st_q.lvl + LVL_W'(push) - LVL_W'(pop_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= {push_tag, push_data};
    end

    assign level = st_q.lvl;

    // R9: the buffer is never written while full
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.lvl < LVL_W'(DEPTH)));

    // R9: a stalled head beat stays put
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/rx_ready_ctrl.sv
module rx_ready_ctrl #(
    parameter int PKT_WORDS = 16,
    parameter int DEPTH     = 32,
    localparam int IDX_W    = $clog2(PKT_WORDS),
    localparam int LVL_W    = $clog2(DEPTH + 1),
    localparam int SUM_W    = LVL_W + 2,
    localparam int DECIDE_IDX = PKT_WORDS - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic             pkt_open,
    input  logic [IDX_W-1:0] pkt_idx,
    output logic             ready_n
);

    typedef struct packed {
        logic ready_n;
    } rdy_st_t;

    rdy_st_t st_q, st_d;
    logic [SUM_W-1:0] pending_w, need_w;
    logic decide_w, fits_w;

    always_comb begin
        st_d      = st_q;
        decide_w  = !pkt_open || (pkt_idx == IDX_W'(DECIDE_IDX));
        pending_w = pkt_open ? SUM_W'(PKT_WORDS) - SUM_W'(pkt_idx) : '0;
        need_w    = SUM_W'(level) + pending_w + SUM_W'(PKT_WORDS);
        fits_w    = (need_w <= SUM_W'(DEPTH));
        if (decide_w) st_d.ready_n = !fits_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ready_n: 1'b1};
        else        st_q <= st_d;
    end

    assign ready_n = st_q.ready_n;

    // R7: inside a packet the ready line moves only at the decision word
    a_r7_held_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_open && (pkt_idx != IDX_W'(DECIDE_IDX))) |=> $stable(ready_n));

endmodule

// File: rtl/pkt_ingress_rx.sv
module pkt_ingress_rx
    import pkt_rx_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PKT_WORDS = 16,
    parameter int BUF_PKTS  = 2,
    localparam int DEPTH    = BUF_PKTS * PKT_WORDS,
    localparam int IDX_W    = $clog2(PKT_WORDS),
    localparam int LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_chk_en,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rx_par,
    input  logic              rx_avail,
    input  logic              rx_sop,
    output logic              rx_ready_n,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic              m_err
);

    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    rx_tag_t           wr_tag;
    rx_tag_t           out_tag;
    logic              pkt_open;
    logic [IDX_W-1:0]  pkt_idx;
    logic [LVL_W-1:0]  level;

    rx_word_framer #(.DATA_W(DATA_W), .PKT_WORDS(PKT_WORDS)) framer_i (
        .clk(clk), .rst_n(rst_n), .par_chk_en(par_chk_en),
        .rx_word(rx_word), .rx_par(rx_par), .rx_avail(rx_avail), .rx_sop(rx_sop),
        .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
        .pkt_open(pkt_open), .pkt_idx(pkt_idx)
    );

    rx_pkt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en), .push_data(wr_data), .push_tag(wr_tag),
        .out_valid(m_valid), .out_ready(m_ready),
        .out_data(m_data), .out_tag(out_tag), .level(level)
    );

    rx_ready_ctrl #(.PKT_WORDS(PKT_WORDS), .DEPTH(DEPTH)) ready_i (
        .clk(clk), .rst_n(rst_n), .level(level),
        .pkt_open(pkt_open), .pkt_idx(pkt_idx), .ready_n(rx_ready_n)
    );

    assign m_last = out_tag.last;
    assign m_err  = out_tag.err;

    // R5: the error flag only ever appears on a packet's final beat
    a_r5_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_last) |-> !m_err);

endmodule

// File: tb/pkt_ingress_rx_tb.sv
module pkt_ingress_rx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 16;
    localparam int WDOG       = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        par_chk_en = 1'b1;
    logic [31:0] rx_word = '0;
    logic        rx_par = 1'b0;
    logic        rx_avail = 1'b0;
    logic        rx_sop = 1'b0;
    logic        rx_ready_n;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [31:0] m_data;
    logic        m_last;
    logic        m_err;

    int checks = 0;
    int errors = 0;
    int wr_i = 0;
    int rd_i = 0;
    int beats = 0;
    bit done = 1'b0;

    logic [31:0] exp_data [0:2047];
    logic        exp_last [0:2047];
    logic        exp_err  [0:2047];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_ingress_rx dut_i (
        .clk(clk), .rst_n(rst_n), .par_chk_en(par_chk_en),
        .rx_word(rx_word), .rx_par(rx_par), .rx_avail(rx_avail), .rx_sop(rx_sop),
        .rx_ready_n(rx_ready_n), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .m_last(m_last), .m_err(m_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_val(input int base, input int i);
        return (32'(base) * 32'h9E3779B1) ^ (32'h1 << i) ^ (32'h8000_0000 >> (2 * i % 32)) ^ 32'(i);
    endfunction

    // Output monitor, R1 R3 R5
    always begin
        @(negedge clk);
        #1;
        if (rst_n && m_valid && m_ready) begin
            if (rd_i >= wr_i) begin
                chk(1'b0, "R2 unexpected beat", m_data, 32'h0);
            end else begin
                chk(m_data == exp_data[rd_i], "R1 data", m_data, exp_data[rd_i]);
                chk(m_last == exp_last[rd_i], "R3 last", 32'(m_last), 32'(exp_last[rd_i]));
                chk(m_err == exp_err[rd_i], "R5 err", 32'(m_err), 32'(exp_err[rd_i]));
                rd_i++;
            end
            beats++;
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_sop = 1'b0; rx_avail = 1'b0; rx_word = '0; rx_par = 1'b1;
        end
    endtask

    // bad_idx: word with wrong parity (-1 none); early_idx: extra start strobe (-1 none)
    task automatic send_pkt(input int base, input int bad_idx, input int early_idx,
                            input bit exp_hi);
        bit perr;
        bit pkt_err;
        perr = (bad_idx >= 0) && par_chk_en;
        pkt_err = perr || (early_idx >= 1);
        for (int i = 0; i < NW; i++) begin
            logic [31:0] w;
            @(negedge clk);
            w = word_val(base, i);
            rx_word  = w;
            rx_par   = (i == bad_idx) ? (^w) : ~(^w);
            rx_sop   = (i == 0) || (i == early_idx);
            rx_avail = 1'b1;
            exp_data[wr_i] = w;
            exp_last[wr_i] = (i == NW - 1);
            exp_err[wr_i]  = (i == NW - 1) && pkt_err;
            wr_i++;
            #1;
            if (i <= NW - 3)
                chk(rx_ready_n == 1'b0, "R7 held low in packet", 32'(rx_ready_n), 32'h0);
            else
                chk(rx_ready_n == exp_hi, "R8 decision", 32'(rx_ready_n), 32'(exp_hi));
        end
    endtask

    task automatic drain(input int limit);
        for (int k = 0; k < limit && rd_i < wr_i; k++) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", rd_i, wr_i);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen;
        bit got_low;
        // R10 reset state
        repeat (3) @(negedge clk);
        #1;
        chk(rx_ready_n == 1'b1, "R10 ready in reset", 32'(rx_ready_n), 32'h1);
        chk(m_valid == 1'b0, "R10 valid in reset", 32'(m_valid), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(rx_ready_n == 1'b0, "R10 ready after reset", 32'(rx_ready_n), 32'h0);

        // R2: unqualified strobe and stray words are ignored
        @(negedge clk);
        rx_sop = 1'b1; rx_avail = 1'b0; rx_word = 32'hDEAD_BEEF; rx_par = 1'b0;
        @(negedge clk);
        rx_sop = 1'b0; rx_avail = 1'b1; rx_word = 32'h1234_5678;
        idle(20);
        #1;
        chk(m_valid == 1'b0, "R2 no output from ignored words", 32'(m_valid), 32'h0);
        chk(wr_i == rd_i, "R2 no beats", 32'(rd_i), 32'(wr_i));

        // clean packets back to back, R1 R3
        for (int p = 0; p < 4; p++) send_pkt(p, -1, -1, 1'b0);
        idle(2);

        // R4 parity sweep, checking enabled
        par_chk_en = 1'b1;
        for (int b = 0; b < NW; b++) begin
            send_pkt(100 + b, b, -1, 1'b0);
            idle(1);
        end
        // R4 parity sweep, checking disabled
        par_chk_en = 1'b0;
        for (int b = 0; b < NW; b++) begin
            send_pkt(200 + b, b, -1, 1'b0);
            idle(1);
        end
        par_chk_en = 1'b1;
        send_pkt(299, -1, -1, 1'b0);
        idle(2);

        // R6 early start strobe at every inner index
        for (int e = 1; e < NW; e++) begin
            send_pkt(300 + e, -1, e, 1'b0);
            idle(1);
        end
        send_pkt(399, -1, -1, 1'b0);
        idle(2);
        drain(100);
        idle(3);

        // R8 R9 backpressure: two packets fill the buffer to its limit
        @(negedge clk);
        m_ready = 1'b0;
        send_pkt(500, -1, -1, 1'b0);
        send_pkt(501, -1, -1, 1'b1);
        idle(10);
        #1;
        chk(rx_ready_n == 1'b1, "R8 full buffer stays not ready", 32'(rx_ready_n), 32'h1);
        chk(m_valid == 1'b1, "R9 held while stalled", 32'(m_valid), 32'h1);
        seen = beats;
        @(negedge clk);
        m_ready = 1'b1;
        got_low = 1'b0;
        for (int k = 0; k < 40 && !got_low; k++) begin
            @(negedge clk);
            #2;
            if (rx_ready_n == 1'b0) got_low = 1'b1;
        end
        chk(got_low, "R8 ready returns after drain", 32'(got_low), 32'h1);
        chk((beats - seen) >= NW, "R8 room for a packet", 32'(beats - seen), 32'(NW));
        idle(2);
        send_pkt(600, -1, -1, 1'b0);
        idle(2);
        drain(200);
        idle(2);
        chk(rd_i == wr_i, "R9 every word delivered", 32'(rd_i), 32'(wr_i));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule